// File: doc/BRIEF.md
# Immediate-Operand Accumulator ALU

This unit executes the instructions that combine an 8-bit literal, held in the low byte of a 13-bit instruction word, with the accumulator. The supported operations are load, bitwise OR, AND and XOR, add, and a reversed subtract that computes literal minus accumulator. The return-with-literal instruction uses the same path to load its literal into the accumulator. The stack side of that instruction is handled elsewhere.

The surrounding core presents one instruction per cycle on `in_valid`, along with the current accumulator and the Z, C and DC flags. One clock later the unit returns the new accumulator and flags. Each flag is rewritten only when the opcode is defined to affect it; otherwise the incoming value is carried through. Encodings outside this group are flagged as not handled and pass accumulator and flags through unchanged.

Internally a decoder maps the top five instruction bits to an enumerated operation: `OP_NONE`, `OP_MOV`, `OP_OR`, `OP_AND`, `OP_XOR`, `OP_RETL`, `OP_SUB` or `OP_ADD`. The result register then moves between two named conditions:
- `ST_IDLE`: no result. It is entered on reset, and after any cycle in which `in_valid` is low. In this state `out_valid` is low and the result registers hold their values.
- `ST_DONE`: a fresh result. It is entered after any cycle in which `in_valid` is high.

Top module: `alu_lit_unit`

## Requirements
- R1: After reset, `out_valid`, `out_hit`, `acc_o`, `z_o`, `c_o` and `dc_o` are all 0.
- R2: Every accepted instruction (`in_valid` high at a rising edge) produces `out_valid` high after exactly that one edge.
- R3: Load literal, with `instr[12:8]` = 11000, sets the accumulator to `instr[7:0]` and returns Z, C and DC unchanged.
- R4: OR (11001), AND (11010) and XOR (11011) combine the literal with the accumulator bitwise, rewrite only Z, and return C and DC unchanged.
- R5: Add (11111) produces (k + A) mod 256. C is the carry out of bit 7 and DC is the carry out of bit 3.
- R6: Subtract (11101) produces (k − A) mod 256. C is 1 exactly when k ≥ A. DC is 1 exactly when k[3:0] ≥ A[3:0].
- R7: For OR, AND, XOR, add and subtract, Z is 1 exactly when the 8-bit result is zero.
- R8: Return-with-literal (11100) loads `instr[7:0]` into the accumulator and returns all flags unchanged.
- R9: Any other encoding (`instr[12]` = 0, or `instr[12:8]` = 11110) gives `out_hit` = 0 and passes the accumulator and all three flags through unchanged. Handled opcodes give `out_hit` = 1.
- R10: A cycle with `in_valid` low drives `out_valid` low and leaves `acc_o`, `out_hit` and the flags at their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 13 | Instruction word; literal in bits 7:0 |
| acc_i | input | 8 | Current accumulator value |
| z_i | input | 1 | Current zero flag |
| c_i | input | 1 | Current carry flag |
| dc_i | input | 1 | Current half-carry flag |
| out_valid | output | 1 | Registered result is fresh |
| out_hit | output | 1 | Instruction belonged to this unit |
| acc_o | output | 8 | New accumulator value |
| z_o | output | 1 | New zero flag |
| c_o | output | 1 | New carry flag |
| dc_o | output | 1 | New half-carry flag |

## Verification
The embedded properties check the following on every cycle:
- the one-cycle latency;
- holding when idle;
- the flags kept by load, return and the logic opcodes;
- pass-through of foreign encodings;
- the add carry compared against a wide sum.

Only the bench's sweeps can show that the arithmetic results are correct, and that the subtract and half-carry flags are right across every pair of operands. The sweeps cover every add and subtract operand pair, and a wide set of values for the logic and load operations. A property cannot cover this without copying the datapath.

// File: rtl/alu_lit_pkg.sv
package alu_lit_pkg;

    localparam int OPC_W = 5;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_MOV,
        OP_OR,
        OP_AND,
        OP_XOR,
        OP_RETL,
        OP_SUB,
        OP_ADD
    } lit_op_e;

    typedef enum logic {
        ST_IDLE,
        ST_DONE
    } res_state_e;

    typedef struct packed {
        logic z;
        logic c;
        logic dc;
    } flags_t;

endpackage

// File: rtl/alu_lit_decode.sv
module alu_lit_decode
    import alu_lit_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    output lit_op_e          op
);

    always_comb begin
        unique case (opc)
            5'b11000: op = OP_MOV;
            5'b11001: op = OP_OR;
            5'b11010: op = OP_AND;
            5'b11011: op = OP_XOR;
            5'b11100: op = OP_RETL;
            5'b11101: op = OP_SUB;
            5'b11111: op = OP_ADD;
            default:  op = OP_NONE;
        endcase
    end

endmodule

// File: rtl/alu_lit_arith.sv
module alu_lit_arith #(
    parameter int DATA_W = 8,
    parameter int HALF_W = 4
) (
    input  logic [DATA_W-1:0] lit,
    input  logic [DATA_W-1:0] acc,
    input  logic              sub,
    output logic [DATA_W-1:0] sum,
    output logic              carry,
    output logic              half_carry
);

    localparam int HI_W = DATA_W - HALF_W;

    logic [DATA_W-1:0] opnd;
    logic [HALF_W:0]   lo_sum;
    logic [HI_W:0]     hi_sum;

    // subtract as k + ~A + 1: carry out means no borrow
    assign opnd = sub ? ~acc : acc;

    always_comb begin
        lo_sum = {1'b0, lit[HALF_W-1:0]} + {1'b0, opnd[HALF_W-1:0]}
               + {{HALF_W{1'b0}}, sub};
        hi_sum = {1'b0, lit[DATA_W-1:HALF_W]} + {1'b0, opnd[DATA_W-1:HALF_W]}
               + {{HI_W{1'b0}}, lo_sum[HALF_W]};
    end

    assign sum        = {hi_sum[HI_W-1:0], lo_sum[HALF_W-1:0]};
    assign carry      = hi_sum[HI_W];
    assign half_carry = lo_sum[HALF_W];

endmodule

// File: rtl/alu_lit_logic.sv
module alu_lit_logic
    import alu_lit_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  lit_op_e           op,
    input  logic [DATA_W-1:0] lit,
    input  logic [DATA_W-1:0] acc,
    output logic [DATA_W-1:0] res
);

    always_comb begin
        unique case (op)
            OP_OR:   res = lit | acc;
            OP_AND:  res = lit & acc;
            OP_XOR:  res = lit ^ acc;
            default: res = lit;
        endcase
    end

endmodule

// File: rtl/alu_lit_unit.sv
module alu_lit_unit
    import alu_lit_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int INSTR_W = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic [DATA_W-1:0]  acc_i,
    input  logic               z_i,
    input  logic               c_i,
    input  logic               dc_i,
    output logic               out_valid,
    output logic               out_hit,
    output logic [DATA_W-1:0]  acc_o,
    output logic               z_o,
    output logic               c_o,
    output logic               dc_o
);

    localparam int HALF_W = DATA_W / 2;

    lit_op_e           op;
    logic [DATA_W-1:0] lit;
    logic [DATA_W-1:0] arith_res;
    logic [DATA_W-1:0] logic_res;
    logic              arith_c;
    logic              arith_dc;
    logic [DATA_W-1:0] nxt_acc;
    flags_t            flg_in;
    flags_t            nxt_flg;
    logic              nxt_hit;
    res_state_e        state_q;
    res_state_e        state_d;
    flags_t            flg_q;
    logic [DATA_W-1:0] acc_q;
    logic              hit_q;

    assign lit    = instr[DATA_W-1:0];
    assign flg_in = '{z: z_i, c: c_i, dc: dc_i};

    alu_lit_decode u_dec (
        .opc (instr[INSTR_W-1 -: OPC_W]),
        .op  (op)
    );

    alu_lit_arith #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_arith (
        .lit        (lit),
        .acc        (acc_i),
        .sub        (op == OP_SUB),
        .sum        (arith_res),
        .carry      (arith_c),
        .half_carry (arith_dc)
    );

    alu_lit_logic #(.DATA_W(DATA_W)) u_logic (
        .op  (op),
        .lit (lit),
        .acc (acc_i),
        .res (logic_res)
    );

    // per-opcode result and flag write selection
    always_comb begin
        nxt_acc = acc_i;
        nxt_flg = flg_in;
        nxt_hit = 1'b1;
        unique case (op)
            OP_MOV, OP_RETL: begin
                nxt_acc = logic_res;
            end
            OP_OR, OP_AND, OP_XOR: begin
                nxt_acc   = logic_res;
                nxt_flg.z = (logic_res == '0);
            end
            OP_SUB, OP_ADD: begin
                nxt_acc    = arith_res;
                nxt_flg.z  = (arith_res == '0);
                nxt_flg.c  = arith_c;
                nxt_flg.dc = arith_dc;
            end
            OP_NONE: begin
                nxt_hit = 1'b0;
            end
        endcase
    end

    // next state
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = in_valid ? ST_DONE : ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            flg_q <= '0;
            hit_q <= 1'b0;
        end else if (in_valid) begin
            acc_q <= nxt_acc;
            flg_q <= nxt_flg;
            hit_q <= nxt_hit;
        end
    end

    assign out_valid = (state_q == ST_DONE);
    assign out_hit   = hit_q;
    assign acc_o     = acc_q;
    assign z_o       = flg_q.z;
    assign c_o       = flg_q.c;
    assign dc_o      = flg_q.dc;

    // ---------------- assertions ----------------
    logic is_keep_all;
    logic is_logic_op;
    logic is_add;
    logic is_foreign;
    assign is_keep_all = (instr[INSTR_W-1 -: OPC_W] == 5'b11000)
                      || (instr[INSTR_W-1 -: OPC_W] == 5'b11100);
    assign is_logic_op = (instr[INSTR_W-1 -: 3] == 3'b110)
                      && (instr[INSTR_W-4 -: 2] != 2'b00);
    assign is_add      = (instr[INSTR_W-1 -: OPC_W] == 5'b11111);
    assign is_foreign  = !instr[INSTR_W-1]
                      || (instr[INSTR_W-1 -: OPC_W] == 5'b11110);

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(acc_o) && $stable(out_hit)
                      && $stable({z_o, c_o, dc_o}));

    p_keep_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && is_keep_all |=> out_hit && acc_o == $past(lit)
            && {z_o, c_o, dc_o} == $past({z_i, c_i, dc_i}));

    p_logic_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && is_logic_op |=> {c_o, dc_o} == $past({c_i, dc_i})
            && z_o == (acc_o == '0));

    p_add_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && is_add |=>
            c_o == $past(({1'b0, lit} + {1'b0, acc_i}) >> DATA_W));

    p_foreign_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && is_foreign |=> !out_hit && acc_o == $past(acc_i)
            && {z_o, c_o, dc_o} == $past({z_i, c_i, dc_i}));

endmodule

// File: tb/alu_lit_unit_test.sv
module alu_lit_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [12:0] instr = '0;
    logic [7:0]  acc_i = '0;
    logic        z_i = 1'b0, c_i = 1'b0, dc_i = 1'b0;
    logic        out_valid, out_hit, z_o, c_o, dc_o;
    logic [7:0]  acc_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // expected output of the previously driven cycle
    bit         pend = 0;
    logic       e_valid, e_hit, e_z, e_c, e_dc;
    logic [7:0] e_acc;
    string      e_tag;

    always #5 clk = ~clk;

    alu_lit_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .acc_i(acc_i), .z_i(z_i), .c_i(c_i), .dc_i(dc_i),
        .out_valid(out_valid), .out_hit(out_hit), .acc_o(acc_o),
        .z_o(z_o), .c_o(c_o), .dc_o(dc_o)
    );

    task automatic check_pend();
        total++;
        if ({out_valid, out_hit, acc_o, z_o, c_o, dc_o} !==
            {e_valid, e_hit, e_acc, e_z, e_c, e_dc}) begin
            bad++;
            $display("FAIL %s: got v=%b hit=%b acc=%02h z=%b c=%b dc=%b exp v=%b hit=%b acc=%02h z=%b c=%b dc=%b",
                     e_tag, out_valid, out_hit, acc_o, z_o, c_o, dc_o,
                     e_valid, e_hit, e_acc, e_z, e_c, e_dc);
        end
    endtask

    // drive one cycle at the falling edge; check the previous one first
    task automatic step(input logic v, input logic [12:0] ins,
                        input logic [7:0] a, input logic [2:0] f);
        int k, s;
        @(negedge clk);
        if (pend) check_pend();
        in_valid = v; instr = ins; acc_i = a; {z_i, c_i, dc_i} = f;
        pend = 1;
        k = int'(ins[7:0]);
        if (!v) begin
            e_valid = 0; e_tag = "R10 idle hold";
            return;
        end
        e_valid = 1; e_hit = 1;
        {e_z, e_c, e_dc} = f;
        unique case (ins[12:8])
            5'b11000: begin e_acc = ins[7:0]; e_tag = "R3 mov"; end
            5'b11100: begin e_acc = ins[7:0]; e_tag = "R8 retl"; end
            5'b11001: begin e_acc = ins[7:0] | a; e_z = (e_acc == 0); e_tag = "R4/R7 or"; end
            5'b11010: begin e_acc = ins[7:0] & a; e_z = (e_acc == 0); e_tag = "R4/R7 and"; end
            5'b11011: begin e_acc = ins[7:0] ^ a; e_z = (e_acc == 0); e_tag = "R4/R7 xor"; end
            5'b11111: begin
                s = k + int'(a);
                e_acc = s[7:0]; e_c = (s > 255);
                e_dc = ((k % 16) + (int'(a) % 16)) > 15;
                e_z = (e_acc == 0); e_tag = "R5/R7 add";
            end
            5'b11101: begin
                s = k - int'(a);
                e_acc = s[7:0]; e_c = (k >= int'(a));
                e_dc = (k % 16) >= (int'(a) % 16);
                e_z = (e_acc == 0); e_tag = "R6/R7 sub";
            end
            default: begin
                e_hit = 0; e_acc = a; e_tag = "R9 foreign";
            end
        endcase
    endtask

    initial begin
        #1_900_000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: got running exp done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        total++;
        if ({out_valid, out_hit, acc_o, z_o, c_o, dc_o} !== 13'b0) begin
            bad++;
            $display("FAIL R1 reset: got %b exp 0",
                     {out_valid, out_hit, acc_o, z_o, c_o, dc_o});
        end
        rst_n = 1'b1;

        // R5 and R6: every operand pair
        for (int a = 0; a < 256; a++)
            for (int k = 0; k < 256; k++) begin
                step(1, {5'b11111, 8'(k)}, 8'(a), 3'(a ^ k));
                step(1, {5'b11101, 8'(k)}, 8'(a), 3'(a + k));
            end
        // R4, R7: logic ops over all literals and many accumulators
        for (int a = 0; a < 256; a += 17)
            for (int k = 0; k < 256; k++) begin
                step(1, {5'b11001, 8'(k)}, 8'(a), 3'(k));
                step(1, {5'b11010, 8'(k)}, 8'(a), 3'(k + 1));
                step(1, {5'b11011, 8'(k)}, 8'(a), 3'(k + 2));
            end
        step(1, {5'b11010, 8'h0F}, 8'hF0, 3'b011);  // AND to zero
        step(1, {5'b11011, 8'hA5}, 8'hA5, 3'b000);  // XOR to zero
        step(1, {5'b11001, 8'h00}, 8'h00, 3'b111);  // OR of zeros
        // R3, R8: loads with every flag combination
        for (int k = 0; k < 256; k++)
            for (int f = 0; f < 8; f++) begin
                step(1, {5'b11000, 8'(k)}, 8'(255 - k), 3'(f));
                step(1, {5'b11100, 8'(k)}, 8'(k + 7), 3'(f));
            end
        // R9: foreign encodings
        for (int h = 0; h < 16; h++)
            for (int f = 0; f < 8; f++)
                step(1, {1'b0, 4'(h), 8'(h * 13 + f)}, 8'(h * 29 + f), 3'(f));
        for (int k = 0; k < 256; k++)
            step(1, {5'b11110, 8'(k)}, 8'(k ^ 8'h5A), 3'(k));
        // R10 and R2: idle gaps between accepted instructions
        step(1, {5'b11111, 8'h80}, 8'h80, 3'b000);
        step(0, {5'b11000, 8'h33}, 8'h44, 3'b111);
        step(0, {5'b11101, 8'h01}, 8'h02, 3'b010);
        step(1, {5'b11101, 8'h10}, 8'h01, 3'b111);
        step(0, 13'h0, 8'h0, 3'b000);
        @(negedge clk);
        check_pend();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule